// File: doc/BRIEF.md
# Synchronous Byte-Lane Write Memory Controller

This block runs the read and write cycles of a single-ported synchronous memory whose word is made of byte lanes, each lane being eight data bits plus one parity bit. Every clock it decides from two address strobes, a select input and three write-control inputs whether the cycle reads, writes some lanes, continues a burst or leaves the memory deselected. It then drives a common-I/O style data output with its own enable. Addresses arrive already sequenced from a separate burst address unit, so the block uses whatever `addr` holds on each edge.

An access opened by the processor strobe always reads in its first cycle, and its write inputs are ignored. An access opened by the controller strobe may write at once. Cycles with both strobes idle continue an open burst. In those cycles the access reads or writes as the write inputs decide. Read data is registered from the address present at the edge. It reaches the output only while output enable is low and no write is being decoded in the present cycle. The array is a behavioural model whose depth is set by `ADDR_W`. The word layout puts lane 0 in bits [8:0] (parity at bit 8) and lane 1 in bits [17:9] (parity at bit 17).

Top module: `sbw_sram`

## Requirements
- R1: With `gw_n` low in a write-capable cycle, every lane of the word at `addr` takes `dq_in`, whatever `bwe_n` and `bws_n` show.
- R2: With `gw_n` high and `bwe_n` low, lane i (bits [9i+8:9i], parity in the top bit) is written only when `bws_n[i]` is low; the other lane keeps its old contents.
- R3: With `gw_n` high and either `bwe_n` high or all `bws_n` bits high, a write-capable cycle is a read.
- R4: When `sel` is high and `ps_n` low, the cycle reads `addr` and opens a burst; the write inputs are ignored and the array is left unchanged.
- R5: When `sel` is high, `ps_n` high and `cs_n` low, the cycle opens a burst and writes the decoded lanes of `dq_in` to `addr` on that same edge.
- R6: With both strobes high while a burst is open, the cycle reads or writes `addr` according to the write decode, so a burst opened by the processor strobe can write on its later cycles.
- R7: While the present inputs decode a write, `dq_oe` is low regardless of `oe_n`.
- R8: After a read edge, `dq_oe` is high exactly while `oe_n` is low (and no write is decoded); with `oe_n` high it is low.
- R9: `dq_out` after a read edge equals the word held at the `addr` sampled on that edge.
- R10: `cs_n` low with `sel` low deselects and closes the burst; `ps_n` low with `sel` low is ignored; a deselected or idle edge leaves `dq_oe` low in the following cycle.
- R11: After reset no burst is open and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Combined chip select, active high |
| ps_n | input | 1 | Processor address strobe, active low |
| cs_n | input | 1 | Controller address strobe, active low |
| addr | input | ADDR_W | Word address from the burst address unit |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bws_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, not registered |
| dq_in | input | LANES*LANE_W | Write data, lane 0 in the low bits |
| dq_out | output | LANES*LANE_W | Read data register |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
The assertions assume that every address read has been written at least once since power-up, so that array contents compared across edges are defined. They also assume that `addr` is stable around the edge, as the burst unit supplies it. The bench first fills the low 64 words with controller-strobe writes and then keeps all random and directed addresses inside that window. It changes inputs only one nanosecond after each rising edge.

// File: rtl/sbw_sram.sv
module sbw_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic                      ps_n,
  input  logic                      cs_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bws_n,
  input  logic                      oe_n,
  input  logic [LANES*LANE_W-1:0]   dq_in,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic                      dq_oe
);
  localparam int W     = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0]     mem [DEPTH];
  logic [W-1:0]     rd_q;
  logic             rd_vld;
  logic             burst;
  logic             ps_go, cs_go, cont, wr_ok;
  logic [LANES-1:0] lanes;
  logic             wr_now, rd_now;

  assign ps_go  = sel & ~ps_n;
  assign cs_go  = ~ps_go & sel & ~cs_n;
  assign cont   = ~ps_go & cs_n & burst;
  assign wr_ok  = cs_go | cont;
  assign lanes  = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bws_n : '0);
  assign wr_now = wr_ok & (|lanes);
  assign rd_now = ps_go | (wr_ok & ~(|lanes));

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wr_now && lanes[i])
        mem[addr][i*LANE_W +: LANE_W] <= dq_in[i*LANE_W +: LANE_W];
    if (rd_now)
      rd_q <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst  <= 1'b0;
      rd_vld <= 1'b0;
    end else begin
      burst  <= ps_go | wr_ok;
      rd_vld <= rd_now;
    end
  end

  assign dq_out = rd_q;
  assign dq_oe  = rd_vld & ~oe_n & ~wr_now;

  assert_write_tristate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |-> !dq_oe);
  assert_oe_high_tristate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
  assert_ps_first_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ps_go |=> (mem[$past(addr)] == $past(mem[addr])));
  assert_deselect_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ps_go && !wr_ok) |=> !dq_oe);
  assert_read_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && !wr_now) |=> (dq_out == $past(mem[addr])));
endmodule

// File: tb/sbw_sram_tb.sv
`timescale 1ns/1ps
module sbw_sram_tb;
  localparam int AW = 10;
  localparam int W  = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel, ps_n, cs_n, gw_n, bwe_n, oe_n;
  logic [1:0]    bws_n;
  logic [AW-1:0] addr;
  logic [W-1:0]  dq_in, dq_out;
  logic          dq_oe;

  logic [W-1:0] model [64];
  logic [W-1:0] m_q;
  logic         m_vld, m_act;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sbw_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(9)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ps_n(ps_n), .cs_n(cs_n), .addr(addr),
    .gw_n(gw_n), .bwe_n(bwe_n), .bws_n(bws_n), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic logic [1:0] lane_dec(logic g, logic b, logic [1:0] s);
    return !g ? 2'b11 : (!b ? ~s : 2'b00);
  endfunction

  function automatic logic wr_cycle(logic act);
    logic ps = sel & ~ps_n;
    logic ok = (~ps & sel & ~cs_n) | (~ps & cs_n & act);
    return ok & (|lane_dec(gw_n, bwe_n, bws_n));
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setin(logic s, logic p, logic c, int a, logic g, logic b,
                       logic [1:0] bw, logic o, logic [W-1:0] d);
    sel = s; ps_n = p; cs_n = c; addr = AW'(a); gw_n = g; bwe_n = b;
    bws_n = bw; oe_n = o; dq_in = d;
  endtask

  task automatic step(string tag);
    logic ps, ok;
    logic [1:0] ln;
    logic exp_oe;
    @(posedge clk);
    ps = sel & ~ps_n;
    ok = (~ps & sel & ~cs_n) | (~ps & cs_n & m_act);
    ln = lane_dec(gw_n, bwe_n, bws_n);
    m_vld = ps | (ok & ~(|ln));
    if (m_vld) m_q = model[addr[5:0]];
    if (ok && ln[0]) model[addr[5:0]][8:0]  = dq_in[8:0];
    if (ok && ln[1]) model[addr[5:0]][17:9] = dq_in[17:9];
    m_act = ps | ok;
    #1;
    exp_oe = m_vld & ~oe_n & ~wr_cycle(m_act);
    chk(tag, W'(dq_oe), W'(exp_oe));
    if (exp_oe) chk(tag, dq_out, m_q);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_act = 0; m_vld = 0; m_q = '0;
    setin(0, 1, 1, 0, 1, 1, 2'b11, 0, '0);
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset oe", W'(dq_oe), '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R11 idle after reset", W'(dq_oe), '0);

    // R5: fill window with controller-strobe global writes
    for (int a = 0; a < 64; a++) begin
      setin(1, 1, 0, a, 0, 1, 2'b11, 0, W'($urandom));
      step("R5 fill");
    end
    // R9/R8: processor-strobe read
    setin(1, 0, 1, 5, 1, 1, 2'b11, 0, '0);      step("R9 ps read");
    setin(0, 1, 1, 0, 1, 1, 2'b11, 0, '0);      step("R10 idle");
    // R4: write inputs ignored on first cycle, confirm by reread
    setin(1, 0, 1, 7, 0, 0, 2'b00, 0, ~model[7]); step("R4 ps ignores write");
    setin(1, 1, 0, 7, 1, 1, 2'b11, 0, '0);      step("R4 reread");
    // R6: burst opened by ps writes on continuation
    setin(1, 0, 1, 9, 1, 1, 2'b11, 0, '0);      step("R6 open");
    setin(1, 1, 1, 10, 1, 0, 2'b01, 0, W'(18'h2abcd)); step("R6 R7 cont write lane1");
    setin(1, 1, 1, 10, 1, 1, 2'b11, 0, '0);     step("R2 R6 reread lane1");
    // R2 lane 0 only, R3 with all selects high
    setin(1, 1, 0, 11, 1, 0, 2'b10, 0, W'(18'h15555)); step("R2 lane0 write");
    setin(1, 1, 1, 11, 1, 0, 2'b11, 0, W'(18'h3ffff)); step("R3 bwe no lanes");
    // R1: gw overrides byte selects
    setin(1, 1, 0, 12, 0, 1, 2'b11, 1, W'(18'h0f0f0)); step("R1 global write");
    setin(1, 1, 1, 12, 1, 1, 2'b11, 0, '0);     step("R1 reread");
    // R7: read then write with oe low
    setin(1, 1, 1, 13, 0, 1, 2'b11, 0, W'(18'h11111)); step("R7 write after read");
    // R8: oe high
    setin(1, 0, 1, 14, 1, 1, 2'b11, 1, '0);     step("R8 oe high");
    // R10: ps with sel low ignored, burst continues as read
    setin(0, 0, 1, 15, 1, 1, 2'b11, 0, '0);     step("R10 ps masked");
    setin(0, 1, 0, 16, 1, 1, 2'b11, 0, '0);     step("R10 deselect");
    setin(1, 1, 1, 17, 1, 1, 2'b11, 0, '0);     step("R10 no burst");

    for (int i = 0; i < 600; i++) begin
      setin(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
            $urandom % 64, ($urandom % 4) != 0, ($urandom % 2) != 0,
            2'($urandom), ($urandom % 4) == 0, W'($urandom));
      step("R6 random mix");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule